// File: doc/BRIEF.md
# Comparator-Gated Timer with Synchronizer

This block is a free-running up-counter whose counting is gated by one of two sources: an external gate pin or the output of an analog comparator. A two-bit configuration register picks the gate source and decides whether the comparator output is resynchronized to the timer clock before it is used as a gate. The timer clock and any prescaling happen outside the block. They arrive as two single-cycle strobes in the system clock domain: one marks the rising edge of the prescaled timer clock and one marks its falling edge.

The counter steps on a rising-edge strobe. When synchronization is on, the comparator value is captured on the falling-edge strobe. Because of this, a comparator transition that lands on a count edge cannot produce a partially sampled gate. A polarity-invert input conditions the comparator output before any use. The conditioned value that is never resynchronized is offered for a pin, together with a drive enable that follows a separate output-enable input. A sticky flag records each wrap of the counter from its maximum value back to zero.

Top module: `cmp_gated_timer`

## Requirements
- R1: After reset the count reads 0, the overflow flag reads 0, and the configuration readback reads 8'h02. That value means source select = 1 and sync enable = 0.
- R2: A configuration write stores wdata[1] as the gate source select and wdata[0] as the sync enable. The readback shows these bits in the same positions, and readback bits 7..2 are always 0.
- R3: With source select = 1 the gate is the gate pin. With source select = 0 the gate is the conditioned comparator value.
- R4: With sync enable = 0 the comparator gate is the conditioned comparator value of the current cycle.
- R5: With sync enable = 1 the comparator gate is the conditioned comparator value captured at the most recent fall strobe. A comparator change in the same cycle as a rise strobe does not affect that rise's increment. The captured value is 0 after reset.
- R6: The count increases by exactly 1 in the cycle after a rise strobe in which the timer enable and the selected gate are both 1. In every other cycle it holds.
- R7: An increment from 16'hFFFF yields 0 and sets the overflow flag. The flag holds until ovf_clr is asserted. A wrap in the same cycle as ovf_clr leaves the flag set.
- R8: The comparator output equals cmp_raw XOR cmp_inv in the same cycle.
- R9: pin_val always equals the conditioned comparator value without resynchronization, whatever the sync enable is. pin_drive equals pin_oe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_rise | input | 1 | Strobe marking the rising edge of the prescaled timer clock |
| tmr_fall | input | 1 | Strobe marking the falling edge of the prescaled timer clock |
| tmr_en | input | 1 | Timer run enable |
| cmp_raw | input | 1 | Raw comparator output |
| cmp_inv | input | 1 | Comparator polarity invert |
| gate_pin | input | 1 | External gate pin |
| pin_oe | input | 1 | Output enable for the comparator pin |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| ovf_clr | input | 1 | Clears the overflow flag |
| cfg_rdata | output | 8 | Configuration readback |
| count | output | 16 | Timer count |
| ovf | output | 1 | Sticky overflow flag |
| cmp_out | output | 1 | Polarity-corrected comparator value |
| pin_val | output | 1 | Unsynchronized comparator value for the pin |
| pin_drive | output | 1 | Pin drive enable |

## Verification
Two events can fall in the same cycle: a change of the comparator input and a rise strobe that increments the counter. The bench provokes this directly. With synchronization on and the comparator selected, it captures a 0 on a fall strobe, then raises the comparator in the same cycle as a rise strobe, and then does the reverse. It expects no increment in the first case and one increment in the second. Random stimulus that lets both strobes and comparator toggles coincide is judged against a bench model of the captured gate, cycle by cycle.

// File: rtl/cgt_pkg.sv
package cgt_pkg;
  localparam int unsigned CNT_W = 16;
  localparam int unsigned CFG_W = 8;
  localparam int unsigned CFG_SRC_BIT  = 1;
  localparam int unsigned CFG_SYNC_BIT = 0;

  typedef struct packed {
    logic src_pin;
    logic sync_en;
  } cgt_cfg_t;
endpackage

// File: rtl/cgt_cfg_reg.sv
module cgt_cfg_reg
  import cgt_pkg::*;
#(
  parameter int unsigned W = CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output cgt_cfg_t     cfg,
  output logic [W-1:0] rdata
);
  cgt_cfg_t cfg_q, cfg_d;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[W-1:CFG_SRC_BIT+1]};

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d.src_pin = wdata[CFG_SRC_BIT];
      cfg_d.sync_en = wdata[CFG_SYNC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.src_pin <= 1'b1;
      cfg_q.sync_en <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[CFG_SRC_BIT]  = cfg_q.src_pin;
    rdata[CFG_SYNC_BIT] = cfg_q.sync_en;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/cgt_cmp_cond.sv
module cgt_cmp_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic fall_stb,
  input  logic raw,
  input  logic inv,
  input  logic sync_en,
  output logic pol,
  output logic sync_q,
  output logic gate
);
  logic sync_d;

  assign pol = raw ^ inv;

  always_comb begin
    sync_d = sync_q;
    if (fall_stb) sync_d = pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 1'b0;
    else        sync_q <= sync_d;
  end

  assign gate = sync_en ? sync_q : pol;
endmodule

// File: rtl/cgt_counter.sv
module cgt_counter
  import cgt_pkg::*;
#(
  parameter int unsigned W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr_ovf,
  output logic [W-1:0] count,
  output logic         ovf
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic [W-1:0] cnt_q, cnt_d;
  logic         ovf_q, ovf_d;
  logic         wrap;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (inc) begin
      cnt_d = cnt_q + W'(1);
      wrap  = (cnt_q == MAXV);
    end
    ovf_d = ovf_q;
    if (clr_ovf) ovf_d = 1'b0;
    if (wrap)    ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign count = cnt_q;
  assign ovf   = ovf_q;
endmodule

// File: rtl/cmp_gated_timer.sv
module cmp_gated_timer
  import cgt_pkg::*;
#(
  parameter int unsigned TW = CNT_W,
  parameter int unsigned CW = CFG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmr_rise,
  input  logic          tmr_fall,
  input  logic          tmr_en,
  input  logic          cmp_raw,
  input  logic          cmp_inv,
  input  logic          gate_pin,
  input  logic          pin_oe,
  input  logic          cfg_we,
  input  logic [CW-1:0] cfg_wdata,
  input  logic          ovf_clr,
  output logic [CW-1:0] cfg_rdata,
  output logic [TW-1:0] count,
  output logic          ovf,
  output logic          cmp_out,
  output logic          pin_val,
  output logic          pin_drive
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  cgt_cfg_t   cfg;
  logic       cmp_pol, cmp_sync_q, cmp_gate;
  logic       gate_sel, inc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  cgt_cfg_reg #(.W(CW)) u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .cfg   (cfg),
    .rdata (cfg_rdata)
  );

  cgt_cmp_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fall_stb (tmr_fall),
    .raw      (cmp_raw),
    .inv      (cmp_inv),
    .sync_en  (cfg.sync_en),
    .pol      (cmp_pol),
    .sync_q   (cmp_sync_q),
    .gate     (cmp_gate)
  );

  assign gate_sel = cfg.src_pin ? gate_pin : cmp_gate;
  assign inc_en   = tmr_rise & tmr_en & gate_sel;

  cgt_counter #(.W(TW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .inc     (inc_en),
    .clr_ovf (ovf_clr),
    .count   (count),
    .ovf     (ovf)
  );

  assign cmp_out   = cmp_pol;
  assign pin_val   = cmp_pol;
  assign pin_drive = pin_oe;
endmodule

// File: rtl/cgt_checker.sv
module cgt_checker #(
  parameter int unsigned TW = 16,
  parameter int unsigned CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmr_rise,
  input logic          tmr_fall,
  input logic          tmr_en,
  input logic          ovf_clr,
  input logic          cfg_we,
  input logic [CW-1:0] cfg_wdata,
  input logic [CW-1:0] cfg_rdata,
  input logic [TW-1:0] count,
  input logic          ovf,
  input logic          gate_sel,
  input logic          sync_q,
  input logic          sync_en,
  input logic          src_pin
);
  AST_CFG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata[1:0] == $past(cfg_wdata[1:0])); // R2

  AST_SYNC_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_fall |=> $stable(sync_q)); // R5

  AST_SYNC_BLOCKS_RACE: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_en && !src_pin && !sync_q) |=> $stable(count)); // R5

  AST_HOLD_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_rise |=> $stable(count)); // R6

  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rise && tmr_en && gate_sel) |=> count == $past(count) + TW'(1)); // R6

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_rise && tmr_en && gate_sel && count == {TW{1'b1}}) |=> (ovf && count == '0)); // R7

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_clr) |=> ovf); // R7
endmodule

bind cmp_gated_timer cgt_checker #(.TW(TW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .tmr_rise  (tmr_rise),
  .tmr_fall  (tmr_fall),
  .tmr_en    (tmr_en),
  .ovf_clr   (ovf_clr),
  .cfg_we    (cfg_we),
  .cfg_wdata (cfg_wdata),
  .cfg_rdata (cfg_rdata),
  .count     (count),
  .ovf       (ovf),
  .gate_sel  (gate_sel),
  .sync_q    (cmp_sync_q),
  .sync_en   (cfg.sync_en),
  .src_pin   (cfg.src_pin)
);

// File: tb/tb_cmp_gated_timer.sv
module tb_cmp_gated_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk, rst_n;
  logic        tmr_rise, tmr_fall, tmr_en, cmp_raw, cmp_inv, gate_pin, pin_oe;
  logic        cfg_we, ovf_clr;
  logic [7:0]  cfg_wdata, cfg_rdata;
  logic [15:0] count;
  logic        ovf, cmp_out, pin_val, pin_drive;

  int n_chk = 0;
  int n_fail = 0;

  // bench model state
  logic        m_src, m_sync, m_cap, m_ovf;
  logic [15:0] m_cnt;

  cmp_gated_timer dut (
    .clk(clk), .rst_n(rst_n), .tmr_rise(tmr_rise), .tmr_fall(tmr_fall),
    .tmr_en(tmr_en), .cmp_raw(cmp_raw), .cmp_inv(cmp_inv), .gate_pin(gate_pin),
    .pin_oe(pin_oe), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ovf_clr(ovf_clr),
    .cfg_rdata(cfg_rdata), .count(count), .ovf(ovf), .cmp_out(cmp_out),
    .pin_val(pin_val), .pin_drive(pin_drive)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_gate(input logic src, input logic sy, input logic cap,
                                    input logic pol, input logic pin);
    logic cg;
    cg = sy ? cap : pol;
    return src ? pin : cg;
  endfunction

  // one cycle: drive after a negedge, check comb, update model, check registers
  task automatic step(input logic rise, input logic fall, input logic en,
                      input logic raw, input logic inv, input logic pin,
                      input logic oe, input logic we, input logic [7:0] wd,
                      input logic clr);
    logic pol, g, wrap;
    tmr_rise = rise; tmr_fall = fall; tmr_en = en; cmp_raw = raw; cmp_inv = inv;
    gate_pin = pin; pin_oe = oe; cfg_we = we; cfg_wdata = wd; ovf_clr = clr;
    #1;
    pol = raw ^ inv;
    chk("R8 cmp_out", {31'd0, cmp_out}, {31'd0, pol});
    chk("R9 pin_val", {31'd0, pin_val}, {31'd0, pol});
    chk("R9 pin_drive", {31'd0, pin_drive}, {31'd0, oe});
    g = exp_gate(m_src, m_sync, m_cap, pol, pin);
    wrap = 1'b0;
    if (rise && en && g) begin
      wrap  = (m_cnt == 16'hFFFF);
      m_cnt = m_cnt + 16'd1;
    end
    if (clr)  m_ovf = 1'b0;
    if (wrap) m_ovf = 1'b1;
    if (fall) m_cap = pol;
    if (we) begin m_src = wd[1]; m_sync = wd[0]; end
    @(negedge clk);
    chk("R6 count", {16'd0, count}, {16'd0, m_cnt});
    chk("R7 ovf", {31'd0, ovf}, {31'd0, m_ovf});
    chk("R2 cfg_rdata", {24'd0, cfg_rdata}, {30'd0, m_src, m_sync});
  endtask

  task automatic idle();
    step(0, 0, 0, cmp_raw, cmp_inv, gate_pin, pin_oe, 0, 8'h00, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    void'($urandom(32'd20250611));
    rst_n = 1'b0;
    tmr_rise = 0; tmr_fall = 0; tmr_en = 0; cmp_raw = 0; cmp_inv = 0;
    gate_pin = 0; pin_oe = 0; cfg_we = 0; cfg_wdata = 0; ovf_clr = 0;
    m_src = 1; m_sync = 0; m_cap = 0; m_ovf = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", {16'd0, count}, 32'd0);
    chk("R1 ovf", {31'd0, ovf}, 32'd0);
    chk("R1 cfg_rdata", {24'd0, cfg_rdata}, 32'h02);

    // R2 unimplemented bits read as zero
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'hFF, 0);
    chk("R2 upper bits zero", {24'd0, cfg_rdata}, 32'h03);

    // R3 pin gate: comparator high but pin low -> no count, pin high -> count
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h02, 0);
    c0 = count;
    step(1, 0, 1, 1, 0, 0, 0, 0, 8'h00, 0);
    chk("R3 pin low blocks", {16'd0, count}, {16'd0, c0});
    step(1, 0, 1, 0, 0, 1, 0, 0, 8'h00, 0);
    chk("R3 pin high counts", {16'd0, count}, {16'd0, c0 + 16'd1});

    // R4 unsynced comparator gate, inverted polarity
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h00, 0);
    c0 = count;
    step(1, 0, 1, 0, 1, 0, 0, 0, 8'h00, 0);
    chk("R4 inverted raw 0 gates on", {16'd0, count}, {16'd0, c0 + 16'd1});
    step(1, 0, 1, 1, 1, 0, 0, 0, 8'h00, 0);
    chk("R4 inverted raw 1 gates off", {16'd0, count}, {16'd0, c0 + 16'd1});

    // R5 race: sync on, capture 0, then raise comparator together with rise
    step(0, 0, 0, 0, 0, 0, 0, 1, 8'h01, 0);
    step(0, 1, 0, 0, 0, 0, 0, 0, 8'h00, 0);
    c0 = count;
    step(1, 0, 1, 1, 0, 0, 1, 0, 8'h00, 0);
    chk("R5 toggle on rise ignored", {16'd0, count}, {16'd0, c0});
    step(0, 1, 0, 1, 0, 0, 1, 0, 8'h00, 0);
    step(1, 0, 1, 0, 0, 0, 1, 0, 8'h00, 0);
    chk("R5 captured 1 counts despite drop", {16'd0, count}, {16'd0, c0 + 16'd1});

    // random mix with coinciding strobes and toggles
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] wd;
      wd = 8'($urandom);
      step(1'($urandom), 1'($urandom), ($urandom % 4) != 0, 1'($urandom),
           ($urandom % 8) == 0, 1'($urandom), 1'($urandom),
           ($urandom % 16) == 0, wd, ($urandom % 32) == 0);
    end

    // R7 wrap: pin gate, count every cycle up to the wrap
    step(0, 0, 0, 0, 0, 1, 0, 1, 8'h02, 1);
    while (m_cnt != 16'hFFFF) step(1, 0, 1, 0, 0, 1, 0, 0, 8'h00, 0);
    chk("R7 no ovf before wrap", {31'd0, ovf}, 32'd0);
    step(1, 0, 1, 0, 0, 1, 0, 0, 8'h00, 0);
    chk("R7 wrap to zero", {16'd0, count}, 32'd0);
    chk("R7 ovf set", {31'd0, ovf}, 32'd1);
    idle();
    chk("R7 ovf sticky", {31'd0, ovf}, 32'd1);
    step(0, 0, 0, 0, 0, 1, 0, 0, 8'h00, 1);
    chk("R7 ovf cleared", {31'd0, ovf}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule